// File: doc/BRIEF.md
# Capability Load Revocation Barrier

This block sits beside a load unit and decides whether a capability that has just come back from memory keeps its valid tag. For every request it receives the base address of the loaded capability and its incoming tag. When the temporal-safety check is enabled and the base falls inside the mapped heap, the block reads one 32-bit word of a shadow revocation bitmap through a simple request/response read port. It then picks out the bit that covers the 8-byte block holding the base and returns the tag cleared if that bit is set. In every other case the tag comes back unchanged and no read is made.

The request side is a valid/ready stream. `req_ready` is high only while the block is idle, so one lookup at most is in flight. A request that does not need the bitmap returns its result one cycle after acceptance, which gives one bypass per cycle. A request that needs the bitmap holds `req_ready` low until its response has been taken. Results leave as a single-cycle `res_valid` pulse with no back-pressure, so the consumer must always capture them. The read port presents `mem_req_valid` with a stable address until `mem_req_ready`. It then accepts exactly one `mem_rsp_valid` beat in a later cycle.

The heap start, the bitmap start and the bitmap size in 32-bit words are parameters. With 1024 words the map holds 32768 bits, which cover 256 KB of heap.

Top module: `cap_revoke_barrier`

## Requirements
- R1: When `tsafe_en` is 0 at acceptance, `res_valid` pulses one cycle after acceptance with `res_tag` equal to `req_tag`, and `mem_req_valid` stays 0.
- R2: When `compat_mode` is 1 at acceptance, the barrier is off. The result is as in R1, with the tag passed through and no read.
- R3: An accepted request with `req_tag` 0 makes no read and returns `res_tag` 0 one cycle later.
- R4: A base below `HEAP_BASE`, or one whose bit index is at least `MAP_WORDS`*32, is not checked. It returns its tag unchanged one cycle after acceptance and makes no read.
- R5: For a checked request, bit index = (base − `HEAP_BASE`) >> 3. `mem_req_addr` = `MAP_BASE` + (bit index >> 5) × 4, and `mem_req_valid` rises in the cycle after acceptance.
- R6: The response bit selected is bit (bit index mod 32) of `mem_rsp_data`, where bit 0 is the LSB. If that bit is 1, `res_tag` is 0. If it is 0, `res_tag` is 1. All other response bits have no effect.
- R7: `req_ready` is 1 only when no lookup is pending, so at most one lookup is outstanding.
- R8: While `mem_req_valid` is 1 and `mem_req_ready` is 0, the next cycle keeps `mem_req_valid` at 1 with the same `mem_req_addr`. After the handshake, `mem_req_valid` drops.
- R9: `res_valid` is asserted exactly one cycle after the awaited `mem_rsp_valid` and lasts one cycle. A `mem_rsp_valid` with no read outstanding is ignored.
- R10: A synchronous active-low `rst_n` clears any pending lookup, `res_valid` and `mem_req_valid`, and leaves `req_ready` at 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| tsafe_en | input | 1 | Enables the revocation check |
| compat_mode | input | 1 | Permissive mode; disables the barrier |
| req_valid | input | 1 | Request valid |
| req_ready | output | 1 | Request accepted when high with req_valid |
| req_base | input | ADDR_W | Base address of the loaded capability |
| req_tag | input | 1 | Incoming valid tag |
| res_valid | output | 1 | Single-cycle result strobe |
| res_tag | output | 1 | Filtered tag |
| mem_req_valid | output | 1 | Bitmap read request |
| mem_req_ready | input | 1 | Read port accepts the request |
| mem_req_addr | output | ADDR_W | Byte address of the bitmap word |
| mem_rsp_valid | input | 1 | Read data valid |
| mem_rsp_data | input | 32 | Bitmap word |

## Verification
A wrong bit index or word address shows up on `mem_req_addr` in the first cycle of the read, or as a wrongly kept or cleared tag at the `res_valid` pulse that follows the response. A corrupted pending state shows up as `req_ready` staying low, a read being repeated or dropped, or a `res_valid` pulse that is missing, repeated or triggered by a stray response. All of these are visible within a cycle or two of the event that caused them. The range-check edges are hit directly: the first heap byte, one byte below it, the last covered byte and the first byte beyond the map.

// File: rtl/cap_rb_pkg.sv
package cap_rb_pkg;
  typedef enum logic [1:0] {
    RB_IDLE  = 2'd0,
    RB_ISSUE = 2'd1,
    RB_WAIT  = 2'd2
  } rb_state_e;

  localparam int unsigned RB_WORD_BITS = 32;
  localparam int unsigned RB_LANE_W    = 5;
endpackage

// File: rtl/rb_region_map.sv
module rb_region_map #(
  parameter int unsigned ADDR_W     = 32,
  parameter logic [31:0] HEAP_BASE  = 32'h8000_0000,
  parameter logic [31:0] MAP_BASE   = 32'h1000_0000,
  parameter int unsigned MAP_WORDS  = 1024,
  parameter int unsigned GRAN_BYTES = 8
) (
  input  logic [ADDR_W-1:0] base,
  output logic              in_map,
  output logic [ADDR_W-1:0] word_addr,
  output logic [4:0]        lane
);
  localparam int unsigned GRAN_SH = $clog2(GRAN_BYTES);
  localparam logic [ADDR_W-1:0] HEAP_B   = ADDR_W'(HEAP_BASE);
  localparam logic [ADDR_W-1:0] MAP_B    = ADDR_W'(MAP_BASE);
  localparam logic [ADDR_W-1:0] MAP_BITS = ADDR_W'(MAP_WORDS * 32);

  logic [ADDR_W-1:0] offset;
  logic [ADDR_W-1:0] bit_idx;
  logic [ADDR_W-1:0] word_off;

  always_comb begin
    offset    = base - HEAP_B;
    bit_idx   = offset >> GRAN_SH;
    word_off  = (bit_idx >> 5) << 2;
    in_map    = (base >= HEAP_B) && (bit_idx < MAP_BITS);
    word_addr = MAP_B + word_off;
    lane      = bit_idx[4:0];
  end
endmodule

// File: rtl/rb_lane_pick.sv
module rb_lane_pick #(
  parameter int unsigned WORD_BITS = 32,
  parameter int unsigned LANE_W    = 5
) (
  input  logic [WORD_BITS-1:0] word,
  input  logic [LANE_W-1:0]    lane,
  output logic                 bit_set
);
  logic [WORD_BITS-1:0] hit;

  for (genvar g = 0; g < WORD_BITS; g++) begin : g_lane
    assign hit[g] = word[g] && (lane == LANE_W'(g));
  end

  assign bit_set = |hit;
endmodule

// File: rtl/cap_revoke_barrier.sv
module cap_revoke_barrier
  import cap_rb_pkg::*;
#(
  parameter int unsigned ADDR_W     = 32,
  parameter logic [31:0] HEAP_BASE  = 32'h8000_0000,
  parameter logic [31:0] MAP_BASE   = 32'h1000_0000,
  parameter int unsigned MAP_WORDS  = 1024,
  parameter int unsigned GRAN_BYTES = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tsafe_en,
  input  logic              compat_mode,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [ADDR_W-1:0] req_base,
  input  logic              req_tag,
  output logic              res_valid,
  output logic              res_tag,
  output logic              mem_req_valid,
  input  logic              mem_req_ready,
  output logic [ADDR_W-1:0] mem_req_addr,
  input  logic              mem_rsp_valid,
  input  logic [31:0]       mem_rsp_data
);
  rb_state_e         state_q;
  logic              res_valid_q;
  logic              res_tag_q;
  logic [4:0]        lane_q;
  logic [ADDR_W-1:0] addr_q;

  logic              in_map;
  logic [ADDR_W-1:0] word_addr;
  logic [4:0]        lane;
  logic              need_check;
  logic              revoked;

  rb_region_map #(
    .ADDR_W    (ADDR_W),
    .HEAP_BASE (HEAP_BASE),
    .MAP_BASE  (MAP_BASE),
    .MAP_WORDS (MAP_WORDS),
    .GRAN_BYTES(GRAN_BYTES)
  ) u_map (
    .base     (req_base),
    .in_map   (in_map),
    .word_addr(word_addr),
    .lane     (lane)
  );

  rb_lane_pick #(
    .WORD_BITS(RB_WORD_BITS),
    .LANE_W   (RB_LANE_W)
  ) u_pick (
    .word   (mem_rsp_data),
    .lane   (lane_q),
    .bit_set(revoked)
  );

  assign need_check = tsafe_en && !compat_mode && req_tag && in_map;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q     <= RB_IDLE;
      res_valid_q <= 1'b0;
      res_tag_q   <= 1'b0;
      lane_q      <= '0;
      addr_q      <= '0;
    end else begin
      res_valid_q <= 1'b0;
      unique case (state_q)
        RB_IDLE: begin
          if (req_valid) begin
            if (need_check) begin
              state_q <= RB_ISSUE;
              addr_q  <= word_addr;
              lane_q  <= lane;
            end else begin
              res_valid_q <= 1'b1;
              res_tag_q   <= req_tag;
            end
          end
        end
        RB_ISSUE: begin
          if (mem_req_ready) state_q <= RB_WAIT;
        end
        RB_WAIT: begin
          if (mem_rsp_valid) begin
            res_valid_q <= 1'b1;
            res_tag_q   <= !revoked;
            state_q     <= RB_IDLE;
          end
        end
        default: state_q <= RB_IDLE;
      endcase
    end
  end

  assign req_ready     = (state_q == RB_IDLE);
  assign mem_req_valid = (state_q == RB_ISSUE);
  assign mem_req_addr  = addr_q;
  assign res_valid     = res_valid_q;
  assign res_tag       = res_tag_q;
endmodule

// File: rtl/rb_checker.sv
module rb_checker #(
  parameter int unsigned ADDR_W = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic              tsafe_en,
  input logic              compat_mode,
  input logic              req_valid,
  input logic              req_ready,
  input logic              req_tag,
  input logic              res_valid,
  input logic              res_tag,
  input logic              mem_req_valid,
  input logic              mem_req_ready,
  input logic [ADDR_W-1:0] mem_req_addr,
  input logic              mem_rsp_valid
);
  logic outstanding;
  logic accept;

  assign accept = req_valid && req_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) outstanding <= 1'b0;
    else if (mem_req_valid && mem_req_ready) outstanding <= 1'b1;
    else if (mem_rsp_valid) outstanding <= 1'b0;
  end

  assert_bypass_disabled_R1: assert property (@(posedge clk) disable iff (!rst_n)
    accept && !tsafe_en |=> res_valid && (res_tag == $past(req_tag)) && !mem_req_valid);

  assert_bypass_compat_R2: assert property (@(posedge clk) disable iff (!rst_n)
    accept && compat_mode |=> res_valid && (res_tag == $past(req_tag)) && !mem_req_valid);

  assert_untagged_R3: assert property (@(posedge clk) disable iff (!rst_n)
    accept && !req_tag |=> res_valid && !res_tag && !mem_req_valid);

  assert_single_flight_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req_valid || outstanding) |-> !req_ready);

  assert_req_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_valid && !mem_req_ready |=> mem_req_valid && $stable(mem_req_addr));

  assert_req_drop_R8: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_valid && mem_req_ready |=> !mem_req_valid);

  assert_rsp_to_result_R9: assert property (@(posedge clk) disable iff (!rst_n)
    outstanding && mem_rsp_valid |=> res_valid);

  assert_result_pulse_R9: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid && $past(outstanding) |=> !res_valid || $past(accept));

  assert_no_overlap_R9: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid |-> !mem_req_valid);

  assert_reset_clears_R10: assert property (@(posedge clk)
    !rst_n |=> !res_valid && !mem_req_valid && req_ready);
endmodule

bind cap_revoke_barrier rb_checker #(.ADDR_W(ADDR_W)) u_rb_checker (
  .clk          (clk),
  .rst_n        (rst_n),
  .tsafe_en     (tsafe_en),
  .compat_mode  (compat_mode),
  .req_valid    (req_valid),
  .req_ready    (req_ready),
  .req_tag      (req_tag),
  .res_valid    (res_valid),
  .res_tag      (res_tag),
  .mem_req_valid(mem_req_valid),
  .mem_req_ready(mem_req_ready),
  .mem_req_addr (mem_req_addr),
  .mem_rsp_valid(mem_rsp_valid)
);

// File: tb/cap_revoke_barrier_test.sv
module cap_revoke_barrier_test;
  localparam logic [31:0] HB = 32'h8000_0000;
  localparam logic [31:0] MB = 32'h1000_0000;
  localparam int unsigned MW = 1024;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        tsafe_en = 1'b0, compat_mode = 1'b0;
  logic        req_valid = 1'b0, req_tag = 1'b0;
  logic [31:0] req_base = '0;
  logic        req_ready, res_valid, res_tag, mem_req_valid;
  logic        mem_req_ready = 1'b0, mem_rsp_valid = 1'b0;
  logic [31:0] mem_req_addr, mem_rsp_data = '0;

  int checks = 0, fails = 0;
  bit done = 0;

  always #5 clk = ~clk;

  cap_revoke_barrier uut (
    .clk(clk), .rst_n(rst_n), .tsafe_en(tsafe_en), .compat_mode(compat_mode),
    .req_valid(req_valid), .req_ready(req_ready), .req_base(req_base), .req_tag(req_tag),
    .res_valid(res_valid), .res_tag(res_tag),
    .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready), .mem_req_addr(mem_req_addr),
    .mem_rsp_valid(mem_rsp_valid), .mem_rsp_data(mem_rsp_data)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] shadow_word(input logic [31:0] a);
    return (a * 32'h9E37_79B1) ^ 32'hA5A5_0F0F;
  endfunction

  function automatic logic in_range(input logic [31:0] b);
    return (b >= HB) && (((b - HB) >> 3) < MW * 32);
  endfunction

  // dsel: 0 hashed word, 1 only the lane bit set, 2 every bit but the lane
  task automatic run_one(input logic [31:0] b, input logic t, input logic en,
                         input logic cm, input int dsel, input string tagname);
    logic        look;
    logic [31:0] idx, waddr, data;
    logic [4:0]  ln;
    look  = en && !cm && t && in_range(b);
    idx   = (b - HB) >> 3;
    waddr = MB + ((idx >> 5) << 2);
    ln    = idx[4:0];
    @(negedge clk);
    chk({tagname, " R7 ready idle"}, 32'(req_ready), 32'd1);
    req_valid = 1; req_base = b; req_tag = t; tsafe_en = en; compat_mode = cm;
    @(negedge clk);
    req_valid = 0;
    if (!look) begin
      chk({tagname, " bypass valid"}, 32'(res_valid), 32'd1);
      chk({tagname, " bypass tag"}, 32'(res_tag), 32'(t));
      chk({tagname, " bypass no read"}, 32'(mem_req_valid), 32'd0);
    end else begin
      chk({tagname, " R5 req valid"}, 32'(mem_req_valid), 32'd1);
      chk({tagname, " R5 addr"}, mem_req_addr, waddr);
      chk({tagname, " R7 busy"}, 32'(req_ready), 32'd0);
      for (int k = 0; k < int'($urandom_range(0, 3)); k++) begin
        @(negedge clk);
        chk({tagname, " R8 hold"}, 32'(mem_req_valid), 32'd1);
        chk({tagname, " R8 addr stable"}, mem_req_addr, waddr);
      end
      mem_req_ready = 1;
      @(negedge clk);
      mem_req_ready = 0;
      chk({tagname, " R8 dropped"}, 32'(mem_req_valid), 32'd0);
      for (int k = 0; k < int'($urandom_range(0, 3)); k++) begin
        @(negedge clk);
        chk({tagname, " R9 no early result"}, 32'(res_valid), 32'd0);
      end
      data = (dsel == 1) ? (32'd1 << ln) : (dsel == 2) ? ~(32'd1 << ln) : shadow_word(waddr);
      mem_rsp_valid = 1; mem_rsp_data = data;
      @(negedge clk);
      mem_rsp_valid = 0; mem_rsp_data = $urandom;
      chk({tagname, " R9 result valid"}, 32'(res_valid), 32'd1);
      chk({tagname, " R6 tag"}, 32'(res_tag), 32'(!data[ln]));
      @(negedge clk);
      chk({tagname, " R9 single pulse"}, 32'(res_valid), 32'd0);
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    rst_n = 1;
    chk("R10 reset ready", 32'(req_ready), 32'd1);
    chk("R10 reset res_valid", 32'(res_valid), 32'd0);
    chk("R10 reset mem_req", 32'(mem_req_valid), 32'd0);

    // stray response while idle
    mem_rsp_valid = 1; mem_rsp_data = '1;
    @(negedge clk);
    mem_rsp_valid = 0;
    chk("R9 stray ignored", 32'(res_valid), 32'd0);
    @(negedge clk);
    chk("R9 stray ignored later", 32'(res_valid), 32'd0);

    run_one(HB + 32'h100, 1, 0, 0, 0, "R1");
    run_one(HB + 32'h100, 1, 1, 1, 0, "R2");
    run_one(HB + 32'h100, 0, 1, 0, 1, "R3");
    run_one(HB - 32'd1,   1, 1, 0, 1, "R4 below");
    run_one(HB + 32'h4_0000, 1, 1, 0, 1, "R4 above");
    run_one(32'h0000_0040, 1, 1, 0, 1, "R4 low");
    run_one(HB,            1, 1, 0, 1, "R6 first revoked");
    run_one(HB + 32'h7,    1, 1, 0, 2, "R6 first kept");
    run_one(HB + 32'h3_FFFF, 1, 1, 0, 1, "R6 last revoked");
    run_one(HB + 32'h3_FFF8, 1, 1, 0, 2, "R6 last kept");
    run_one(HB + 32'h1_2348, 1, 1, 0, 1, "R5 mid");

    // reset while a read is pending
    @(negedge clk);
    req_valid = 1; req_base = HB + 32'h80; req_tag = 1; tsafe_en = 1; compat_mode = 0;
    @(negedge clk);
    req_valid = 0;
    chk("R10 pending read", 32'(mem_req_valid), 32'd1);
    rst_n = 0;
    @(negedge clk);
    rst_n = 1;
    chk("R10 cleared read", 32'(mem_req_valid), 32'd0);
    chk("R10 cleared ready", 32'(req_ready), 32'd1);
    mem_rsp_valid = 1; mem_rsp_data = '1;
    @(negedge clk);
    mem_rsp_valid = 0;
    chk("R10 R9 no stale result", 32'(res_valid), 32'd0);

    for (int i = 0; i < 300; i++) begin
      logic [31:0] b;
      int pick;
      pick = int'($urandom_range(0, 3));
      b = (pick == 0) ? $urandom : HB + ($urandom & 32'h0004_7FFF);
      run_one(b, 1'($urandom_range(0, 7) != 0), 1'($urandom_range(0, 5) != 0),
              1'($urandom_range(0, 7) == 0), 0, "R5 R6 random");
    end

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule